// File: doc/BRIEF.md
# Interrupt and Reset Sequencer

This block runs the multi-cycle entry sequence of an 8-bit CPU core for four kinds of event: power-on or warm reset, a non-maskable request, a maskable request and the software break instruction. When more than one is pending it picks one by fixed priority. For everything except reset it pushes the return address and the status byte onto a stack that grows downward, through a byte-wide memory port. It then fetches a two-byte little-endian vector and hands the core a new program counter, status byte and stack pointer, marked by a one-cycle done strobe.

The core feeds in its current PC, status and stack pointer, plus a strobe from its decoder when a break opcode is seen. When `done` pulses, the core is expected to copy `new_pc`, `new_status` and `new_sp` into its own registers. The memory port assumes a synchronous RAM: read data belongs to the address presented one cycle earlier. Decode, the ALU and the return-from-interrupt path are outside this block.

Top module: `intr_seq`

## Requirements
- R1: After `rst` is released the block runs a reset sequence. It loads `new_pc` from bytes $FFFC (low) and $FFFD (high), leaves `new_sp` equal to `cur_sp`, and keeps `mem_we` low during the whole sequence. While `rst` is high, `done` and `mem_we` are low.
- R2: A rising edge on `nmi_req` starts a sequence with three stack writes on consecutive cycles, at addresses $0100+SP, $0100+SP-1 and $0100+SP-2. The bytes written are PC[15:8], PC[7:0] and the status byte, in that order. The vector comes from $FFFA/$FFFB and `new_sp` = SP-3.
- R3: `irq_req` is level-sensitive and is ignored while status bit 2 (interrupt disable) of `cur_status` is 1. When it is serviced, the vector comes from $FFFE/$FFFF.
- R4: A `brk_hit` pulse runs the same push sequence and vector as R3. The stacked status byte has bit 4 set to 1, and bit 4 of `new_status` equals bit 4 of `cur_status`.
- R5: For NMI and IRQ entries, bit 4 of the stacked status byte is 0.
- R6: On every entry, bit 2 of `new_status` is 1 and bit 3 (decimal) is 0. The other bits are copied from `cur_status`. The stacked status byte keeps the prior bit 3.
- R7: Among requests pending in the same cycle, the service order is reset, break, NMI, IRQ.
- R8: An NMI request is latched on its rising edge and serviced once. Holding `nmi_req` high does not cause a second service.
- R9: A request arriving while a sequence runs does not change that sequence's writes, vector or results. It is serviced in a later sequence.
- R10: Asserting `rst` in the middle of a sequence abandons that sequence, and the next result is the reset vector.
- R11: The high vector address, which is the low one plus 1, is presented one cycle after the low one. `done` is high for exactly one cycle, three cycles after the low vector address is presented, and `new_pc` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also requests the reset sequence |
| nmi_req | input | 1 | Non-maskable request, edge-sensitive |
| irq_req | input | 1 | Maskable request, level-sensitive |
| brk_hit | input | 1 | One-cycle strobe from the decoder for a break opcode |
| cur_pc | input | 16 | Return address to be stacked |
| cur_status | input | 8 | Current processor status byte |
| cur_sp | input | 8 | Current stack pointer (offset within page $01) |
| mem_rdata | input | 8 | Read data for the address of the previous cycle |
| mem_addr | output | 16 | Memory address, registered |
| mem_wdata | output | 8 | Memory write data, registered |
| mem_we | output | 1 | Memory write enable, registered |
| new_pc | output | 16 | Program counter loaded from the vector |
| new_status | output | 8 | Status byte after entry |
| new_sp | output | 8 | Stack pointer after the pushes |
| done | output | 1 | One-cycle strobe: new_pc, new_status and new_sp are valid |

## Verification
A wrong sequencer state shows up within one or two cycles as a stack write at the wrong offset, a write in the wrong order, or a write during reset. A wrong kind latched at grant shows up four cycles later as a wrong vector address, and at `done` as a wrong PC or a wrong stacked bit 4. Faults in the pending latches show up only at sequence boundaries: a lost break or NMI, a doubled NMI, or an unmasked IRQ. Those faults are visible only when the next `done` is counted, so the bench drives each collision and then watches the following one or two sequences to the end.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  // order of the kinds mirrors service priority, highest first
  typedef enum logic [1:0] {K_RST, K_BRK, K_NMI, K_IRQ} kind_e;
  typedef enum logic [2:0] {
    S_IDLE, S_PSH_H, S_PSH_L, S_PSH_P, S_VEC_L, S_VEC_H, S_FIN
  } state_e;
endpackage

// File: rtl/intr_arb.sv
module intr_arb
  import intr_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  nmi_req,
  input  logic  irq_req,
  input  logic  brk_hit,
  input  logic  irq_mask,
  input  logic  take,
  output logic  req_valid,
  output kind_e req_kind
);
  logic rst_pend, brk_pend, nmi_pend, nmi_prev;
  logic nmi_edge, brk_any, nmi_any;

  assign nmi_edge = nmi_req & ~nmi_prev;
  assign brk_any  = brk_pend | brk_hit;
  assign nmi_any  = nmi_pend | nmi_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pend <= 1'b1;
      brk_pend <= 1'b0;
      nmi_pend <= 1'b0;
      nmi_prev <= nmi_req;
    end else begin
      nmi_prev <= nmi_req;
      rst_pend <= rst_pend & ~(take && req_kind == K_RST);
      brk_pend <= brk_any  & ~(take && req_kind == K_BRK);
      nmi_pend <= nmi_any  & ~(take && req_kind == K_NMI);
    end
  end

  always_comb begin
    req_valid = 1'b1;
    if (rst_pend)                  req_kind = K_RST;
    else if (brk_any)              req_kind = K_BRK;
    else if (nmi_any)              req_kind = K_NMI;
    else begin
      req_kind  = K_IRQ;
      req_valid = irq_req & ~irq_mask;
    end
  end

  // R7: reset outranks every other pending request
  p_rst_first_r7: assert property (@(posedge clk) disable iff (rst)
    rst_pend |-> (req_valid && req_kind == K_RST));
  // R7: a pending break outranks NMI and IRQ
  p_brk_over_hw_r7: assert property (@(posedge clk) disable iff (rst)
    (brk_pend && !rst_pend) |-> (req_kind == K_BRK));
  // R8: a latched NMI stays latched until granted
  p_nmi_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend && !take) |=> nmi_pend);
endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
  import intr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SP_W   = 8,
  parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI = 'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST = 'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ = 'hFFFE,
  parameter int unsigned B_BIT = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  kind_e             req_kind,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [DATA_W-1:0] cur_status,
  input  logic [SP_W-1:0]   cur_sp,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              take,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              fin,
  output kind_e             kind_q,
  output logic [DATA_W-1:0] vec_lo_q,
  output logic [DATA_W-1:0] st_q,
  output logic [SP_W-1:0]   sp_q
);
  localparam logic [SP_W-1:0]   SP_ONE = SP_W'(1);
  localparam logic [SP_W-1:0]   SP_TWO = SP_W'(2);
  localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(1);

  state_e state, state_n;
  logic [ADDR_W-1:0] pc_q;
  kind_e             eff_kind;
  logic [ADDR_W-1:0] eff_pc;
  logic [SP_W-1:0]   eff_sp;
  logic [DATA_W-1:0] stk_status;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] wdata_n;
  logic              we_n;

  function automatic logic [ADDR_W-1:0] vec_base(input kind_e k);
    case (k)
      K_RST:   vec_base = VEC_RST;
      K_NMI:   vec_base = VEC_NMI;
      default: vec_base = VEC_IRQ;
    endcase
  endfunction

  always_comb begin
    state_n = state;
    take    = 1'b0;
    case (state)
      S_IDLE: if (req_valid) begin
        take    = 1'b1;
        state_n = (req_kind == K_RST) ? S_VEC_L : S_PSH_H;
      end
      S_PSH_H: state_n = S_PSH_L;
      S_PSH_L: state_n = S_PSH_P;
      S_PSH_P: state_n = S_VEC_L;
      S_VEC_L: state_n = S_VEC_H;
      S_VEC_H: state_n = S_FIN;
      default: state_n = S_IDLE;
    endcase
  end

  assign eff_kind = take ? req_kind   : kind_q;
  assign eff_pc   = take ? cur_pc     : pc_q;
  assign eff_sp   = take ? cur_sp     : sp_q;

  always_comb begin
    stk_status        = st_q;
    stk_status[B_BIT] = (kind_q == K_BRK);
  end

  // bus values for the state entered at the next edge
  always_comb begin
    addr_n  = mem_addr;
    wdata_n = '0;
    we_n    = 1'b0;
    case (state_n)
      S_PSH_H: begin
        addr_n  = {STACK_PAGE, eff_sp};
        wdata_n = eff_pc[ADDR_W-1 -: DATA_W];
        we_n    = 1'b1;
      end
      S_PSH_L: begin
        addr_n  = {STACK_PAGE, sp_q - SP_ONE};
        wdata_n = pc_q[DATA_W-1:0];
        we_n    = 1'b1;
      end
      S_PSH_P: begin
        addr_n  = {STACK_PAGE, sp_q - SP_TWO};
        wdata_n = stk_status;
        we_n    = 1'b1;
      end
      S_VEC_L: addr_n = vec_base(eff_kind);
      S_VEC_H: addr_n = mem_addr + A_ONE;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      kind_q    <= K_RST;
      pc_q      <= '0;
      st_q      <= '0;
      sp_q      <= '0;
      vec_lo_q  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
    end else begin
      state     <= state_n;
      mem_addr  <= addr_n;
      mem_wdata <= wdata_n;
      mem_we    <= we_n;
      if (take) begin
        kind_q <= req_kind;
        pc_q   <= cur_pc;
        st_q   <= cur_status;
        sp_q   <= cur_sp;
      end
      if (state == S_VEC_H) vec_lo_q <= mem_rdata;
    end
  end

  assign fin = (state == S_FIN);

  // R2: every write lands in the stack page
  p_stack_page_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:SP_W] == STACK_PAGE));
  // R2: second push is one below the first
  p_push_descend_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_PSH_L) |-> (mem_addr[SP_W-1:0] == $past(mem_addr[SP_W-1:0]) - SP_ONE));
  // R1: no writes while a reset sequence runs
  p_rst_nowrite_r1: assert property (@(posedge clk) disable iff (rst)
    (kind_q == K_RST && state != S_IDLE) |-> !mem_we);
  // R11: high vector byte address follows the low one
  p_vec_pair_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_VEC_H) |-> (mem_addr == $past(mem_addr) + A_ONE));
endmodule

// File: rtl/intr_result.sv
module intr_result
  import intr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SP_W   = 8,
  parameter int unsigned I_BIT  = 2,
  parameter int unsigned D_BIT  = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              fin,
  input  kind_e             kind_q,
  input  logic [DATA_W-1:0] vec_lo_q,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] st_q,
  input  logic [SP_W-1:0]   sp_q,
  output logic [ADDR_W-1:0] new_pc,
  output logic [DATA_W-1:0] new_status,
  output logic [SP_W-1:0]   new_sp,
  output logic              done
);
  localparam int unsigned   PUSHES = 3;
  localparam logic [DATA_W-1:0] I_MASK = DATA_W'(1) << I_BIT;
  localparam logic [DATA_W-1:0] D_MASK = DATA_W'(1) << D_BIT;
  localparam logic [SP_W-1:0]   SP_DROP = SP_W'(PUSHES);

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      new_pc     <= '0;
      new_status <= '0;
      new_sp     <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        new_pc     <= {mem_rdata, vec_lo_q};
        new_status <= (st_q & ~D_MASK) | I_MASK;
        new_sp     <= (kind_q == K_RST) ? sp_q : sp_q - SP_DROP;
      end
    end
  end

  // R11: done is a single-cycle strobe
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: entry always masks IRQ and leaves decimal mode
  p_status_flags_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (new_status[I_BIT] && !new_status[D_BIT]));
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SP_W   = 8,
  parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI = 'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST = 'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ = 'hFFFE,
  parameter int unsigned I_BIT = 2,
  parameter int unsigned D_BIT = 3,
  parameter int unsigned B_BIT = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_req,
  input  logic              irq_req,
  input  logic              brk_hit,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [DATA_W-1:0] cur_status,
  input  logic [SP_W-1:0]   cur_sp,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] new_pc,
  output logic [DATA_W-1:0] new_status,
  output logic [SP_W-1:0]   new_sp,
  output logic              done
);
  logic              req_valid, take, fin;
  kind_e             req_kind, kind_q;
  logic [DATA_W-1:0] vec_lo_q, st_q;
  logic [SP_W-1:0]   sp_q;

  intr_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .nmi_req   (nmi_req),
    .irq_req   (irq_req),
    .brk_hit   (brk_hit),
    .irq_mask  (cur_status[I_BIT]),
    .take      (take),
    .req_valid (req_valid),
    .req_kind  (req_kind)
  );

  intr_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W(SP_W), .STACK_PAGE(STACK_PAGE),
    .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ), .B_BIT(B_BIT)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .cur_pc     (cur_pc),
    .cur_status (cur_status),
    .cur_sp     (cur_sp),
    .mem_rdata  (mem_rdata),
    .take       (take),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .fin        (fin),
    .kind_q     (kind_q),
    .vec_lo_q   (vec_lo_q),
    .st_q       (st_q),
    .sp_q       (sp_q)
  );

  intr_result #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W(SP_W), .I_BIT(I_BIT), .D_BIT(D_BIT)
  ) u_res (
    .clk        (clk),
    .rst        (rst),
    .fin        (fin),
    .kind_q     (kind_q),
    .vec_lo_q   (vec_lo_q),
    .mem_rdata  (mem_rdata),
    .st_q       (st_q),
    .sp_q       (sp_q),
    .new_pc     (new_pc),
    .new_status (new_status),
    .new_sp     (new_sp),
    .done       (done)
  );
endmodule

// File: tb/test_intr_seq.sv
module test_intr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_req = 1'b0, irq_req = 1'b0, brk_hit = 1'b0;
  logic [15:0] cur_pc = 16'h0000;
  logic [7:0]  cur_status = 8'h00, cur_sp = 8'hFF;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] mem_addr, new_pc;
  logic [7:0]  mem_wdata, new_status, new_sp;
  logic        mem_we, done;

  int n_chk = 0, n_fail = 0;
  int wcnt, lo_idx, done_idx;
  bit got_done;
  logic [15:0] w_addr [8];
  logic [7:0]  w_data [8];
  int          w_idx  [8];
  logic [15:0] addr_log [64];
  logic [15:0] d_pc;
  logic [7:0]  d_st, d_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_seq i_intr_seq (
    .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_req(irq_req), .brk_hit(brk_hit),
    .cur_pc(cur_pc), .cur_status(cur_status), .cur_sp(cur_sp), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .new_pc(new_pc), .new_status(new_status), .new_sp(new_sp), .done(done)
  );

  function automatic logic [7:0] rom(input logic [15:0] a);
    case (a)
      16'hFFFA: rom = 8'h34;  16'hFFFB: rom = 8'h12;
      16'hFFFC: rom = 8'h00;  16'hFFFD: rom = 8'hC0;
      16'hFFFE: rom = 8'h65;  16'hFFFF: rom = 8'h87;
      default:  rom = 8'hEE;
    endcase
  endfunction

  always @(posedge clk) mem_rdata <= rom(mem_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // observe up to maxc cycles; stop at done and feed results back as a core would
  task automatic run_seq(input int maxc, input int nmi_at);
    got_done = 0; wcnt = 0; lo_idx = -1; done_idx = -1;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (k == 0) brk_hit = 1'b0;
      if (k == nmi_at) nmi_req = 1'b1;
      if (k < 64) addr_log[k] = mem_addr;
      if (mem_we && wcnt < 8) begin
        w_addr[wcnt] = mem_addr; w_data[wcnt] = mem_wdata; w_idx[wcnt] = k; wcnt++;
      end
      if (!mem_we && lo_idx < 0 &&
          (mem_addr == 16'hFFFA || mem_addr == 16'hFFFC || mem_addr == 16'hFFFE))
        lo_idx = k;
      if (done) begin
        got_done = 1; done_idx = k;
        d_pc = new_pc; d_st = new_status; d_sp = new_sp;
        cur_pc = new_pc; cur_status = new_status; cur_sp = new_sp;
        break;
      end
    end
  endtask

  task automatic check_push(input string tag, input logic [7:0] sp, input logic [15:0] pc,
                            input logic [7:0] st);
    chk(wcnt == 3, {tag, " write count"}, wcnt, 3);
    chk(w_addr[0] == {8'h01, sp} && w_data[0] == pc[15:8], {tag, " push hi"}, {w_addr[0], w_data[0]}, {8'h01, sp, pc[15:8]});
    chk(w_addr[1] == {8'h01, sp - 8'd1} && w_data[1] == pc[7:0], {tag, " push lo"}, {w_addr[1], w_data[1]}, {8'h01, sp - 8'd1, pc[7:0]});
    chk(w_addr[2] == {8'h01, sp - 8'd2} && w_data[2] == st, {tag, " push status"}, {w_addr[2], w_data[2]}, {8'h01, sp - 8'd2, st});
    chk(w_idx[1] == w_idx[0] + 1 && w_idx[2] == w_idx[0] + 2, {tag, " push cycles"}, w_idx[2] - w_idx[0], 2);
  endtask

  task automatic t_reset;
    rst = 1'b1; cur_status = 8'h2B; cur_sp = 8'hFD;
    repeat (3) @(negedge clk);
    chk(!done && !mem_we, "R1 outputs idle in reset", {done, mem_we}, 0);
    rst = 1'b0;
    run_seq(20, -1);
    chk(got_done, "R1 reset completes", got_done, 1);
    chk(wcnt == 0, "R1 no write in reset", wcnt, 0);
    chk(d_pc == 16'hC000, "R1 reset vector", d_pc, 16'hC000);
    chk(d_sp == 8'hFD, "R1 sp kept", d_sp, 8'hFD);
    chk(d_st == 8'h27, "R6 reset flags", d_st, 8'h27);
    chk(done_idx - lo_idx == 3 && addr_log[lo_idx+1] == 16'hFFFD, "R11 reset vector timing",
        done_idx - lo_idx, 3);
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
  endtask

  task automatic t_nmi;
    cur_pc = 16'hABCD; cur_status = 8'h28; cur_sp = 8'hF0;
    nmi_req = 1'b1;
    run_seq(20, -1);
    nmi_req = 1'b0;
    chk(got_done, "R2 nmi completes", got_done, 1);
    check_push("R2 R5 nmi", 8'hF0, 16'hABCD, 8'h28);
    chk(d_pc == 16'h1234, "R2 nmi vector", d_pc, 16'h1234);
    chk(d_sp == 8'hED, "R2 nmi sp", d_sp, 8'hED);
    chk(d_st == 8'h24, "R6 nmi live status", d_st, 8'h24);
    chk(lo_idx == w_idx[2] + 1 && addr_log[lo_idx+1] == 16'hFFFB && done_idx == lo_idx + 3,
        "R11 nmi vector timing", done_idx - lo_idx, 3);
  endtask

  task automatic t_irq;
    cur_pc = 16'h0300; cur_status = 8'h04; cur_sp = 8'hE0;
    irq_req = 1'b1;
    run_seq(20, -1);
    chk(!got_done && wcnt == 0, "R3 irq masked", {got_done, wcnt[7:0]}, 0);
    cur_status = 8'h00;
    run_seq(20, -1);
    irq_req = 1'b0;
    chk(got_done && d_pc == 16'h8765, "R3 irq vector", d_pc, 16'h8765);
    check_push("R3 R5 irq", 8'hE0, 16'h0300, 8'h00);
  endtask

  task automatic t_brk;
    cur_pc = 16'h4455; cur_status = 8'h09; cur_sp = 8'hC0;
    brk_hit = 1'b1;
    run_seq(20, -1);
    chk(got_done && d_pc == 16'h8765, "R4 brk vector", d_pc, 16'h8765);
    check_push("R4 brk", 8'hC0, 16'h4455, 8'h19);
    chk(d_st == 8'h05, "R4 R6 brk live status", d_st, 8'h05);
  endtask

  task automatic t_priority;
    cur_pc = 16'h1000; cur_status = 8'h00; cur_sp = 8'hB0;
    brk_hit = 1'b1; nmi_req = 1'b1; irq_req = 1'b1;
    run_seq(20, -1);
    chk(got_done && d_pc == 16'h8765 && w_data[2][4], "R7 brk first", {d_pc, w_data[2]}, {16'h8765, 8'h10});
    run_seq(20, -1);
    chk(got_done && d_pc == 16'h1234, "R7 nmi second", d_pc, 16'h1234);
    run_seq(20, -1);
    chk(!got_done, "R7 irq stays masked", got_done, 0);
    irq_req = 1'b0; nmi_req = 1'b0;
  endtask

  task automatic t_collide;
    cur_pc = 16'h2222; cur_status = 8'h00; cur_sp = 8'hA0;
    brk_hit = 1'b1;
    run_seq(20, 1);
    chk(got_done && d_pc == 16'h8765, "R9 brk not swallowed", d_pc, 16'h8765);
    check_push("R9 brk under nmi", 8'hA0, 16'h2222, 8'h10);
    run_seq(20, -1);
    chk(got_done && d_pc == 16'h1234 && d_sp == 8'h9A, "R9 nmi after brk", {d_pc, d_sp}, {16'h1234, 8'h9A});
    nmi_req = 1'b0;
  endtask

  task automatic t_nmi_held;
    @(negedge clk);
    cur_status = 8'h04; cur_sp = 8'h90;
    nmi_req = 1'b1;
    run_seq(20, -1);
    chk(got_done, "R8 nmi serviced", got_done, 1);
    run_seq(40, -1);
    chk(!got_done && wcnt == 0, "R8 nmi once while held", got_done, 0);
    nmi_req = 1'b0;
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    cur_status = 8'h00; cur_sp = 8'h80;
    nmi_req = 1'b1;
    run_seq(2, -1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; nmi_req = 1'b0;
    run_seq(20, -1);
    chk(got_done && d_pc == 16'hC000, "R10 reset vector after abort", d_pc, 16'hC000);
    chk(wcnt == 0 && d_sp == 8'h80, "R10 no push after abort", {wcnt[7:0], d_sp}, {8'h00, 8'h80});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_nmi();
    t_irq();
    t_brk();
    t_priority();
    t_collide();
    t_nmi_held();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule